// File: doc/BRIEF.md
# ADC Power-Mode Command Sequencer

This block drives the two control pins of a serial converter, the convert strobe and the serial clock, so that the converter can be sent to nap or sleep and brought back. The converter selects its low-power state by counting convert strobes issued while the serial clock is held at one level. Two strobes select nap. A total of four or more selects sleep. Any movement of the serial clock brings it back. The sequencer generates these pin patterns itself. It also runs a model of the converter-side mode logic on its own pin outputs, so the system always knows the state the converter is in.

A host issues one of three commands on a small request port: nap, sleep or wake. The port takes a command only while the sequencer is idle, and each accepted command ends with a one-cycle done pulse. Leaving sleep needs a reference-settling interval. For a programmable number of cycles the block reports a waking state and keeps the conversion-permit output low.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, mode is 2'b00 (active), cmd_ready is 1, cmd_done is 0, conv_o and sck_o are low, and conv_permit is 1.
- R2: Command code 2'b01 (nap) produces exactly two conv_o pulses with sck_o held still. From active the mode becomes 2'b01.
- R3: Command code 2'b10 (sleep) produces exactly four conv_o pulses with sck_o held still, and the mode becomes 2'b10. Sleep is entered only on a conv_o rising edge.
- R4: The strobe count carries across commands until an sck_o edge is seen. A third strobe leaves the mode at nap, and a fourth strobe moves it to sleep, so nap issued while in nap ends in sleep.
- R5: Every sck_o edge clears the strobe count. An edge seen in nap returns the mode straight to active, with no waking interval.
- R6: An sck_o edge seen in sleep sets mode 2'b11 (waking) for exactly SETTLE_CYC clock cycles, then mode 2'b00. While waking, conv_permit and settle_busy are low and high respectively, and no conv_o pulse is issued.
- R7: Command code 2'b11 (wake) produces WAKE_PULSES sck_o pulses and no conv_o pulse. From active the mode stays active.
- R8: Every generated pulse on conv_o or sck_o stays high for at least PULSE_W cycles, and the two pins are low for at least PULSE_W cycles between pulses.
- R9: A command presented while cmd_ready is 0, or with code 2'b00, is dropped. It causes no pin activity and no done pulse.
- R10: Each accepted command gives one cmd_done pulse exactly one cycle long. For wake out of sleep the pulse comes after the waking interval has ended. cmd_ready is 1 again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 nap, 10 sleep, 11 wake |
| cmd_ready | output | 1 | Sequencer idle; commands are taken only now |
| cmd_done | output | 1 | One-cycle pulse when an accepted command completes |
| conv_o | output | 1 | Convert strobe pin to the converter |
| sck_o | output | 1 | Serial clock pin to the converter |
| mode | output | 2 | Tracked converter state: 00 active, 01 nap, 10 sleep, 11 waking |
| conv_permit | output | 1 | Conversions may be started |
| settle_busy | output | 1 | Reference-settling interval running |

## Verification
The bench walks a command sequence that visits every transition. It watches for strobe counts that wrongly reset between commands: in that case a nap issued in nap would stay in nap instead of falling into sleep. It also watches for a nap that passes through waking, and for a waking interval that is one cycle too long or too short, which shows up as a wrong count of cycles at mode 11. Requests made during the waking interval and requests with code 00 must leave the pins quiet. A controller that latched such a request would emit strobes or a stray done pulse. The bench also catches a premature sleep on the third strobe, and pulses narrower than the minimum width.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_NAP    = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_WAKING = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_NAP   = 2'b01,
    OP_SLEEP = 2'b10,
    OP_WAKE  = 2'b11
  } pwr_op_e;

  localparam int NAP_STROBES   = 2;
  localparam int SLEEP_STROBES = 4;
  localparam int STROBE_CNT_W  = 3;

  // Saturating strobe counter step: stops at the sleep threshold.
  function automatic logic [STROBE_CNT_W-1:0] strobe_bump(
    input logic [STROBE_CNT_W-1:0] c
  );
    if (c >= STROBE_CNT_W'(SLEEP_STROBES)) return STROBE_CNT_W'(SLEEP_STROBES);
    return c + STROBE_CNT_W'(1);
  endfunction

  // State selected by a given strobe count with the clock frozen.
  function automatic pwr_mode_e mode_for_count(
    input pwr_mode_e cur,
    input logic [STROBE_CNT_W-1:0] c
  );
    if (c >= STROBE_CNT_W'(SLEEP_STROBES)) return MODE_SLEEP;
    if (c >= STROBE_CNT_W'(NAP_STROBES))   return MODE_NAP;
    return cur;
  endfunction

  // Number of convert strobes a host command emits.
  function automatic int strobes_for_op(input pwr_op_e op);
    case (op)
      OP_NAP:   return NAP_STROBES;
      OP_SLEEP: return SLEEP_STROBES;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_pulse_gen.sv
module pwr_pulse_gen #(
  parameter int PULSE_W = 2,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             pin,
  output logic             busy,
  output logic             done
);
  localparam int PH_W = (PULSE_W < 2) ? 1 : $clog2(PULSE_W);
  localparam logic [PH_W-1:0] PH_LOAD = PH_W'(PULSE_W - 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= '0;
      left  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && (count != '0)) begin
          busy  <= 1'b1;
          pin   <= 1'b1;
          phase <= PH_LOAD;
          left  <= count;
        end
      end else if (phase != '0) begin
        phase <= phase - PH_W'(1);
      end else if (pin) begin
        pin   <= 1'b0;
        phase <= PH_LOAD;
      end else if (left == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
        left <= '0;
      end else begin
        pin   <= 1'b1;
        phase <= PH_LOAD;
        left  <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwr_mode_tracker.sv
module pwr_mode_tracker
  import adc_pwr_seq_pkg::*;
#(
  parameter int   SETTLE_CYC = 100000,
  parameter logic SCK_IDLE   = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      conv_pin,
  input  logic      sck_pin,
  output pwr_mode_e mode,
  output logic      conv_rise,
  output logic      sck_edge,
  output logic      settle_busy
);
  localparam int ST_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [ST_W-1:0] ST_LOAD = ST_W'(SETTLE_CYC - 1);

  logic                    conv_q, sck_q;
  logic [STROBE_CNT_W-1:0] strobes;
  logic [ST_W-1:0]         settle;

  assign conv_rise   = conv_pin & ~conv_q;
  assign sck_edge    = sck_pin ^ sck_q;
  assign settle_busy = (settle != '0) || (mode == MODE_WAKING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q  <= 1'b0;
      sck_q   <= SCK_IDLE;
      strobes <= '0;
      settle  <= '0;
      mode    <= MODE_ACTIVE;
    end else begin
      conv_q <= conv_pin;
      sck_q  <= sck_pin;
      if (mode == MODE_WAKING) begin
        strobes <= '0;
        if (settle == '0) mode <= MODE_ACTIVE;
        else              settle <= settle - ST_W'(1);
      end else if (sck_edge) begin
        strobes <= '0;
        if (mode == MODE_SLEEP) begin
          mode   <= MODE_WAKING;
          settle <= ST_LOAD;
        end else begin
          mode <= MODE_ACTIVE;
        end
      end else if (conv_rise) begin
        strobes <= strobe_bump(strobes);
        mode    <= mode_for_count(mode, strobe_bump(strobes));
      end
    end
  end
endmodule

// File: rtl/pwr_cmd_ctrl.sv
module pwr_cmd_ctrl
  import adc_pwr_seq_pkg::*;
#(
  parameter int WAKE_PULSES = 1,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  pwr_mode_e        mode,
  input  logic             conv_fin,
  input  logic             sck_fin,
  output logic             conv_start,
  output logic             sck_start,
  output logic [CNT_W-1:0] conv_count,
  output logic [CNT_W-1:0] sck_count,
  output logic             ready,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_SETTLE} ctrl_st_e;
  ctrl_st_e st;
  pwr_op_e  op_in;

  assign op_in = pwr_op_e'(cmd_op);
  assign ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      conv_start <= 1'b0;
      sck_start  <= 1'b0;
      conv_count <= '0;
      sck_count  <= '0;
      done       <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      sck_start  <= 1'b0;
      done       <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid && (op_in != OP_NONE)) begin
            st <= ST_PULSE;
            if (op_in == OP_WAKE) begin
              sck_start <= 1'b1;
              sck_count <= CNT_W'(WAKE_PULSES);
            end else begin
              conv_start <= 1'b1;
              conv_count <= CNT_W'(strobes_for_op(op_in));
            end
          end
        end
        ST_PULSE: begin
          if (conv_fin || sck_fin) begin
            if (mode == MODE_WAKING) begin
              st <= ST_SETTLE;
            end else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: begin
          if (mode != MODE_WAKING) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int   PULSE_W     = 2,
  parameter int   SETTLE_CYC  = 100000,
  parameter int   WAKE_PULSES = 1,
  parameter logic SCK_IDLE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       cmd_done,
  output logic       conv_o,
  output logic       sck_o,
  output logic [1:0] mode,
  output logic       conv_permit,
  output logic       settle_busy
);
  localparam int MAX_PULSES = (WAKE_PULSES > SLEEP_STROBES) ? WAKE_PULSES : SLEEP_STROBES;
  localparam int CNT_W      = $clog2(MAX_PULSES + 1);
  localparam int N_CH       = 2; // channel 0: convert strobe, channel 1: serial clock

  logic             gen_start [N_CH];
  logic [CNT_W-1:0] gen_count [N_CH];
  logic             gen_pin   [N_CH];
  logic             gen_busy  [N_CH];
  logic             gen_done  [N_CH];

  pwr_mode_e mode_q;
  logic      conv_rise, sck_edge;

  pwr_cmd_ctrl #(.WAKE_PULSES(WAKE_PULSES), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .mode       (mode_q),
    .conv_fin   (gen_done[0]),
    .sck_fin    (gen_done[1]),
    .conv_start (gen_start[0]),
    .sck_start  (gen_start[1]),
    .conv_count (gen_count[0]),
    .sck_count  (gen_count[1]),
    .ready      (cmd_ready),
    .done       (cmd_done)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_pin
    pwr_pulse_gen #(.PULSE_W(PULSE_W), .CNT_W(CNT_W)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gen_start[ch]),
      .count (gen_count[ch]),
      .pin   (gen_pin[ch]),
      .busy  (gen_busy[ch]),
      .done  (gen_done[ch])
    );
  end

  assign conv_o = gen_pin[0];
  assign sck_o  = gen_pin[1] ^ SCK_IDLE;

  pwr_mode_tracker #(.SETTLE_CYC(SETTLE_CYC), .SCK_IDLE(SCK_IDLE)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_pin    (conv_o),
    .sck_pin     (sck_o),
    .mode        (mode_q),
    .conv_rise   (conv_rise),
    .sck_edge    (sck_edge),
    .settle_busy (settle_busy)
  );

  assign mode        = mode_q;
  assign conv_permit = (mode_q == MODE_ACTIVE) && !gen_busy[0];
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int PULSE_W    = 2,
  parameter int SETTLE_CYC = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       conv_o,
  input logic       sck_o,
  input logic       conv_rise,
  input logic       sck_edge,
  input logic       cmd_done
);
  localparam logic [1:0] M_ACT = 2'b00, M_NAP = 2'b01, M_SLP = 2'b10, M_WAK = 2'b11;

  int unsigned wcnt;
  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt   <= 0;
      hi_len <= 0;
    end else begin
      wcnt   <= (mode == M_WAK) ? wcnt + 1 : 0;
      hi_len <= conv_o ? hi_len + 1 : 0;
    end
  end

  assert_sleep_via_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_SLP && !conv_rise) |=> (mode != M_SLP));
  assert_sleep_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLP && !sck_edge) |=> (mode == M_SLP));
  assert_waking_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAK && wcnt != SETTLE_CYC - 1) |=> (mode == M_WAK));
  assert_waking_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAK) |-> (wcnt < SETTLE_CYC));
  assert_no_strobe_waking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAK) |-> !conv_rise);
  assert_clock_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |-> $stable(sck_o));
  assert_nap_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NAP && sck_edge) |=> (mode == M_ACT));
  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> (hi_len >= PULSE_W));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.PULSE_W(PULSE_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .conv_o    (conv_o),
  .sck_o     (sck_o),
  .conv_rise (conv_rise),
  .sck_edge  (sck_edge),
  .cmd_done  (cmd_done)
);

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
  localparam int PW  = 2;
  localparam int SET = 50;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_ready, cmd_done, conv_o, sck_o, conv_permit, settle_busy;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  int conv_n = 0, sck_n = 0, wak_n = 0, dn_n = 0;
  int cs = 0, cs_prev = 0;
  int run_c = 0, run_s = 0, min_run = 1000;
  logic pc = 0, ps = 0, busy_perm_bad = 0, saw3 = 0;

  always #10 clk = ~clk;

  adc_pwr_seq #(.PULSE_W(PW), .SETTLE_CYC(SET), .WAKE_PULSES(1)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_o && !pc) begin conv_n++; cs++; end
      if (sck_o != ps) cs = 0;
      if (sck_o && !ps) sck_n++;
      if (mode == 2'b11) begin
        wak_n++;
        if (conv_permit || !settle_busy) busy_perm_bad = 1;
      end
      if (cmd_done) dn_n++;
      if (conv_o != pc) begin if (pc && run_c < min_run) min_run = run_c; run_c = 1; end
      else run_c++;
      if (sck_o != ps) begin if (ps && run_s < min_run) min_run = run_s; run_s = 1; end
      else run_s++;
      if (cs_prev == 3 && !saw3) begin
        saw3 = 1;
        check("R4 third strobe keeps nap", mode, 2'b01);
      end
      cs_prev = cs;
      pc = conv_o;
      ps = sck_o;
    end
  end

  task automatic clear_counts();
    conv_n = 0; sck_n = 0; wak_n = 0; dn_n = 0;
  endtask

  task automatic run_cmd(input logic [1:0] op);
    int k;
    @(negedge clk);
    check("R10 ready before command", cmd_ready, 1);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
    k = 0;
    while (!cmd_done && k < 5000) begin @(negedge clk); k++; end
    check("R10 done seen", cmd_done, 1);
    @(negedge clk);
    check("R10 done one cycle", cmd_done, 0);
    check("R10 ready after done", cmd_ready, 1);
  endtask

  // {op, mode, conv pulses, sck pulses, waking expected}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    13'b01_01_0010_0000_0, // R2 nap from active
    13'b11_00_0000_0001_0, // R5 wake from nap
    13'b10_10_0100_0000_0, // R3 sleep
    13'b11_00_0000_0001_1, // R6 wake from sleep
    13'b01_01_0010_0000_0, // R2 nap
    13'b01_10_0010_0000_0, // R4 nap while in nap
    13'b10_10_0100_0000_0, // R4 sleep while in sleep
    13'b11_00_0000_0001_1, // R6
    13'b11_00_0000_0001_0, // R7 wake from active
    13'b01_01_0010_0000_0, // R5 count cleared by wake
    13'b11_00_0000_0001_0  // R5
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 done", cmd_done, 0);
    check("R1 conv", conv_o, 0);
    check("R1 sck", sck_o, 0);
    check("R1 permit", conv_permit, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      clear_counts();
      run_cmd(VEC[i][12:11]);
      check("R2/R3 mode after command", mode, VEC[i][10:9]);
      check("R2/R3 conv pulses", conv_n, VEC[i][8:5]);
      check("R7 sck pulses", sck_n, VEC[i][4:1]);
      check("R6 waking cycles", wak_n, VEC[i][0] ? SET : 0);
      check("R10 done count", dn_n, 1);
    end
    check("R4 third strobe observed", saw3, 1);
    check("R6 permit low and busy high while waking", busy_perm_bad, 0);
    check("R8 minimum pulse width", (min_run >= PW) ? 1 : 0, 1);

    // R9: code 00 is dropped
    clear_counts();
    @(negedge clk); cmd_valid = 1; cmd_op = 2'b00;
    @(negedge clk); cmd_valid = 0;
    repeat (30) @(negedge clk);
    check("R9 op none pulses", conv_n + sck_n, 0);
    check("R9 op none done", dn_n, 0);
    check("R9 op none mode", mode, 0);

    // R9: request during waking interval is dropped
    run_cmd(2'b10);
    clear_counts();
    @(negedge clk); cmd_valid = 1; cmd_op = 2'b11;
    @(negedge clk); cmd_valid = 0; cmd_op = 2'b00;
    while (mode != 2'b11) @(negedge clk);
    check("R9 ready low while waking", cmd_ready, 0);
    cmd_valid = 1; cmd_op = 2'b01;
    @(negedge clk); cmd_valid = 0; cmd_op = 2'b00;
    repeat (SET + 40) @(negedge clk);
    check("R9 busy request no strobes", conv_n, 0);
    check("R9 busy request single done", dn_n, 1);
    check("R9 busy request mode", mode, 0);
    check("R6 permit after settle", conv_permit, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule